// File: doc/BRIEF.md
# Load Result Formatter and Writeback

This block sits at the end of a load pipeline. It takes one returned memory word for a load. That word is 128 bits wide and comes with the byte offset of the access inside it, a size code, a destination register index and a fault flag. The block turns it into one or more 32-bit register-file writes. For sub-word sizes it selects the addressed byte lane and widens the value to 32 bits, with zero or sign extension. For 64- and 128-bit sizes it splits the value over consecutive registers, lowest bytes first.

A request is taken in any cycle where `req_valid` is high and the block is not busy. The writes then follow, one per cycle, starting in the next cycle. `done` pulses for one cycle after the last write. A faulted access writes zero to every destination register it would have filled. Writes aimed at register index 0, which is hardwired to zero, are dropped, but each still uses its cycle slot.

Top module: `load_wb_formatter`

## Requirements
- R1: Size codes on `req_size` are 0 = unsigned byte, 1 = signed byte, 2 = unsigned half (16 bits), 3 = signed half, 4 = word (32 bits), 5 = double (64 bits), 6 = quad (128 bits). The unused code 7 behaves as code 4.
- R2: Unsigned byte and half loads write the selected value zero-extended to 32 bits.
- R3: Signed byte and half loads write the selected value sign-extended to 32 bits from its top bit.
- R4: The selected lane starts at byte `req_offset` of `req_data` (byte n is bits 8n+7..8n). The offset is first forced down to a multiple of the access size: bit 0 is cleared for halves, bits 1..0 for words, bits 2..0 for doubles, and all four bits for quads.
- R5: A double load writes two registers, `dest` then `dest+1`, and the lower-addressed four bytes go to `dest`.
- R6: A quad load writes four registers, `dest` to `dest+3`, in ascending order. Register `dest+k` receives bytes 4k..4k+3 of the word.
- R7: When a request is accepted, its writes appear in the cycles that follow, one per cycle. `busy` is high exactly during those cycles. `done` is high for one cycle, in the cycle right after the last write.
- R8: With `req_fault` high, every register the size would write receives zero.
- R9: Register indices wrap modulo 32. A write slot whose index is 0 keeps `rf_we` low but still takes its cycle.
- R10: A request presented while `busy` is high is ignored. The writes in progress and the later outputs are unchanged.
- R11: During reset and just after it, `busy`, `done` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load result present |
| req_data | input | 128 | Returned memory word |
| req_offset | input | 4 | Byte offset of the access within the word |
| req_size | input | 3 | Size and sign code |
| req_dest | input | 5 | First destination register index |
| req_fault | input | 1 | Access faulted; write zeros |
| busy | output | 1 | Writes in progress, new requests ignored |
| done | output | 1 | One-cycle pulse after the last write |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |

## Verification
A corrupted slot counter or stored count shows at the ports within the same request. The write burst comes out the wrong length, `done` moves off the cycle after the last write, or an index repeats or is skipped. A wrong lane or a wrong extension choice shows as bad `rf_wdata` in the first write slot. A lost fault flag shows as non-zero data one cycle after acceptance. A request that leaks in while busy changes the write index or data in the next cycle, or starts an extra burst after `done`.

// File: rtl/lwb_pkg.sv
// Shared definitions for the load result formatter.
// Assumes a 32-bit register file and at most four registers per load.
package lwb_pkg;
    typedef enum logic [2:0] {
        SZ_U8   = 3'd0,
        SZ_S8   = 3'd1,
        SZ_U16  = 3'd2,
        SZ_S16  = 3'd3,
        SZ_W32  = 3'd4,
        SZ_W64  = 3'd5,
        SZ_W128 = 3'd6,
        SZ_RSV  = 3'd7
    } lwb_size_e;
endpackage

// File: rtl/lwb_format.sv
// Combinational formatter: aligns the offset to the access size, selects the
// byte lane, extends sub-word values and slices wide values into register
// words (lowest bytes to word 0). Forces all words to zero on fault.
// Assumes DATA_W is a multiple of WORD_W and WORD_W >= 16.
module lwb_format
    import lwb_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int WORD_W = 32,
    parameter int NW     = DATA_W / WORD_W,
    parameter int OFF_W  = $clog2(DATA_W / 8),
    parameter int CNT_W  = $clog2(NW) + 1
) (
    input  logic [DATA_W-1:0]          data,
    input  logic [OFF_W-1:0]           off,
    input  logic [2:0]                 size,
    input  logic                       fault,
    output logic [NW-1:0][WORD_W-1:0]  words,
    output logic [CNT_W-1:0]           count
);
    localparam int DBL_WORDS = 2;

    logic [OFF_W-1:0]  aoff;
    logic [DATA_W-1:0] shifted;

    // Force the byte offset down to the natural alignment of the size.
    always_comb begin
        case (lwb_size_e'(size))
            SZ_U8, SZ_S8:   aoff = off;
            SZ_U16, SZ_S16: aoff = {off[OFF_W-1:1], 1'b0};
            SZ_W64:         aoff = {off[OFF_W-1:3], 3'b000};
            SZ_W128:        aoff = '0;
            default:        aoff = {off[OFF_W-1:2], 2'b00};
        endcase
    end

    // Bring the addressed lane down to bit 0.
    always_comb begin
        shifted = data >> {aoff, 3'b000};
    end

    // Build register words and their count from the aligned lane.
    always_comb begin
        words = '0;
        count = CNT_W'(1);
        case (lwb_size_e'(size))
            SZ_U8:  words[0] = {{(WORD_W-8){1'b0}}, shifted[7:0]};
            SZ_S8:  words[0] = {{(WORD_W-8){shifted[7]}}, shifted[7:0]};
            SZ_U16: words[0] = {{(WORD_W-16){1'b0}}, shifted[15:0]};
            SZ_S16: words[0] = {{(WORD_W-16){shifted[15]}}, shifted[15:0]};
            SZ_W64: begin
                for (int i = 0; i < DBL_WORDS; i++)
                    words[i] = shifted[i*WORD_W +: WORD_W];
                count = CNT_W'(DBL_WORDS);
            end
            SZ_W128: begin
                for (int i = 0; i < NW; i++)
                    words[i] = shifted[i*WORD_W +: WORD_W];
                count = CNT_W'(NW);
            end
            default: words[0] = shifted[WORD_W-1:0];
        endcase
        if (fault)
            words = '0;
    end

    // R5/R6: only single, double or full-width counts may leave the formatter.
    always_comb begin
        a_r6_count_legal: assert ($onehot(count) && count <= CNT_W'(NW))
            else $error("formatter count out of range");
    end
endmodule

// File: rtl/lwb_seq.sv
// Writeback sequencer: captures formatted words on accept, then issues one
// register write per cycle in ascending index order, suppresses index 0,
// and pulses done in the cycle after the last slot.
// Assumes count is 1..NW when a request is accepted.
module lwb_seq #(
    parameter int WORD_W = 32,
    parameter int NW     = 4,
    parameter int AW     = 5,
    parameter int CNT_W  = $clog2(NW) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [NW-1:0][WORD_W-1:0]  words,
    input  logic [CNT_W-1:0]           count,
    input  logic [AW-1:0]              dest,
    output logic                       busy,
    output logic                       done,
    output logic                       rf_we,
    output logic [AW-1:0]              rf_waddr,
    output logic [WORD_W-1:0]          rf_wdata
);
    localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;

    logic                       active;
    logic                       done_q;
    logic [CNT_W-1:0]           idx;
    logic [CNT_W-1:0]           cnt_q;
    logic [AW-1:0]              dest_q;
    logic [NW-1:0][WORD_W-1:0]  words_q;
    logic                       accept;
    logic                       last;

    assign accept = req_valid && !active;
    assign last   = (idx == cnt_q - CNT_W'(1));

    // Control state: burst activity, slot index and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= active && last;
            if (accept) begin
                active <= 1'b1;
                idx    <= '0;
                cnt_q  <= count;
            end else if (active) begin
                if (last)
                    active <= 1'b0;
                else
                    idx <= idx + CNT_W'(1);
            end
        end
    end

    // Payload capture: destination and formatted words, held during the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q  <= '0;
            words_q <= '0;
        end else if (accept) begin
            dest_q  <= dest;
            words_q <= words;
        end
    end

    // Write port: index wraps modulo the register count, index 0 dropped.
    always_comb begin
        rf_waddr = dest_q + AW'(idx);
        rf_wdata = words_q[idx[IDX_W-1:0]];
        rf_we    = active && (rf_waddr != '0);
    end

    assign busy = active;
    assign done = done_q;

    // R7: an accepted request starts a burst at slot 0 in the next cycle.
    a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (active && idx == '0));

    // R7: the last slot ends the burst and raises done one cycle later.
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (active && last) |=> (done_q && !active));

    // R7: the slot index never reaches the captured count.
    a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx < cnt_q));

    // R10: a request during a burst leaves the captured payload untouched.
    a_r10_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (active && req_valid) |=> ($stable(dest_q) && $stable(words_q)));

    // R7: done never overlaps a write slot.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !rf_we);
endmodule

// File: rtl/load_wb_formatter.sv
// Top of the load result formatter: formats the returned memory word and
// sequences the resulting register-file writes.
// Assumes the register file has 2**REG_AW entries with entry 0 hardwired zero.
module load_wb_formatter #(
    parameter int DATA_W = 128,
    parameter int WORD_W = 32,
    parameter int REG_AW = 5,
    parameter int NW     = DATA_W / WORD_W,
    parameter int OFF_W  = $clog2(DATA_W / 8),
    parameter int CNT_W  = $clog2(NW) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [2:0]        req_size,
    input  logic [REG_AW-1:0] req_dest,
    input  logic              req_fault,
    output logic              busy,
    output logic              done,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [WORD_W-1:0] rf_wdata
);
    logic [NW-1:0][WORD_W-1:0] fmt_words;
    logic [CNT_W-1:0]          fmt_count;

    lwb_format #(
        .DATA_W(DATA_W), .WORD_W(WORD_W), .NW(NW), .OFF_W(OFF_W), .CNT_W(CNT_W)
    ) u_format (
        .data  (req_data),
        .off   (req_offset),
        .size  (req_size),
        .fault (req_fault),
        .words (fmt_words),
        .count (fmt_count)
    );

    lwb_seq #(
        .WORD_W(WORD_W), .NW(NW), .AW(REG_AW), .CNT_W(CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .words     (fmt_words),
        .count     (fmt_count),
        .dest      (req_dest),
        .busy      (busy),
        .done      (done),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata)
    );
endmodule

// File: tb/load_wb_formatter_test.sv
module load_wb_formatter_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [127:0] req_data = '0;
    logic [3:0]   req_offset = '0;
    logic [2:0]   req_size = '0;
    logic [4:0]   req_dest = '0;
    logic         req_fault = 1'b0;
    logic         busy, done, rf_we;
    logic [4:0]   rf_waddr;
    logic [31:0]  rf_wdata;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    load_wb_formatter uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_offset(req_offset), .req_size(req_size), .req_dest(req_dest),
        .req_fault(req_fault), .busy(busy), .done(done), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int size_bytes(input logic [2:0] sz);
        case (sz)
            3'd0, 3'd1: return 1;
            3'd2, 3'd3: return 2;
            3'd5:       return 8;
            3'd6:       return 16;
            default:    return 4;
        endcase
    endfunction

    function automatic int exp_count(input logic [2:0] sz);
        int nb = size_bytes(sz);
        return (nb <= 4) ? 1 : nb / 4;
    endfunction

    // Expected word k, built byte by byte from the requirements.
    function automatic logic [31:0] exp_word(input logic [127:0] d, input logic [3:0] off,
                                             input logic [2:0] sz, input logic flt, input int k);
        int nb = size_bytes(sz);
        int a  = int'(off) - (int'(off) % nb);
        logic [31:0] v = '0;
        if (flt) return 32'h0;
        if (nb < 4) begin
            for (int j = 0; j < nb; j++) v[8*j +: 8] = d[8*(a+j) +: 8];
            if ((sz == 3'd1 || sz == 3'd3) && v[8*nb-1])
                for (int j = 8*nb; j < 32; j++) v[j] = 1'b1;
        end else begin
            for (int j = 0; j < 4; j++) v[8*j +: 8] = d[8*(a+4*k+j) +: 8];
        end
        return v;
    endfunction

    // Issues one request and checks every write slot and the done pulse.
    task automatic run_req(input logic [2:0] sz, input logic [3:0] off, input logic [4:0] dst,
                           input logic flt, input logic [127:0] d, input string req,
                           input bit poke_busy);
        int n = exp_count(sz);
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_offset = off; req_dest = dst;
        req_fault = flt; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [4:0] ea = dst + 5'(k);
            if (k >= 2) req_valid = 1'b0;
            chk(busy == 1'b1, req, "busy during slot", 64'(busy), 64'd1);
            chk(done == 1'b0, req, "done during slot", 64'(done), 64'd0);
            chk(rf_we == (ea != 5'd0), req, "write enable", 64'(rf_we), 64'(ea != 5'd0));
            if (ea != 5'd0) begin
                chk(rf_waddr == ea, req, "write index", 64'(rf_waddr), 64'(ea));
                chk(rf_wdata == exp_word(d, off, sz, flt, k), req, "write data",
                    64'(rf_wdata), 64'(exp_word(d, off, sz, flt, k)));
            end
            if (poke_busy && k == 1) begin
                req_valid = 1'b1; req_dest = dst ^ 5'h15; req_data = ~d;
                req_size = 3'd0; req_fault = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(done == 1'b1, req, "done after last", 64'(done), 64'd1);
        chk(busy == 1'b0, req, "idle after last", 64'(busy), 64'd0);
        chk(rf_we == 1'b0, req, "no write after last", 64'(rf_we), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, req, "done one cycle", 64'(done), 64'd0);
        chk(rf_we == 1'b0 && busy == 1'b0, req, "stays idle", 64'({busy, rf_we}), 64'd0);
    endtask

    localparam logic [127:0] PAT = 128'hF1E2D3C4_B5A69788_79685A4B_3C2D1E0F;

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !rf_we, "R11", "outputs in reset", 64'({busy, done, rf_we}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rf_we, "R11", "outputs after reset", 64'({busy, done, rf_we}), 64'd0);
    endtask

    task automatic t_subword();
        run_req(3'd0, 4'd15, 5'd4, 1'b0, PAT, "R2", 0);   // unsigned byte, top bit set
        run_req(3'd1, 4'd15, 5'd4, 1'b0, PAT, "R3", 0);   // signed byte, negative
        run_req(3'd1, 4'd3,  5'd5, 1'b0, PAT, "R3", 0);   // signed byte, positive
        run_req(3'd2, 4'd13, 5'd6, 1'b0, PAT, "R4", 0);   // half, odd offset aligned down
        run_req(3'd3, 4'd14, 5'd6, 1'b0, PAT, "R3", 0);   // signed half, negative
        run_req(3'd4, 4'd7,  5'd7, 1'b0, PAT, "R4", 0);   // word, offset aligned down
        run_req(3'd7, 4'd9,  5'd7, 1'b0, PAT, "R1", 0);   // unused code acts as word
    endtask

    task automatic t_wide();
        run_req(3'd5, 4'd11, 5'd10, 1'b0, PAT, "R5", 0);
        run_req(3'd5, 4'd2,  5'd12, 1'b0, PAT, "R5", 0);
        run_req(3'd6, 4'd9,  5'd16, 1'b0, PAT, "R6", 0);
    endtask

    task automatic t_fault();
        run_req(3'd6, 4'd0, 5'd20, 1'b1, PAT, "R8", 0);
        run_req(3'd1, 4'd15, 5'd3, 1'b1, PAT, "R8", 0);
    endtask

    task automatic t_index();
        run_req(3'd6, 4'd0, 5'd0,  1'b0, PAT, "R9", 0);   // first slot suppressed
        run_req(3'd6, 4'd0, 5'd30, 1'b0, PAT, "R9", 0);   // wraps through index 0
        run_req(3'd4, 4'd0, 5'd0,  1'b0, PAT, "R9", 0);   // single write dropped
    endtask

    task automatic t_busy();
        run_req(3'd6, 4'd0, 5'd8, 1'b0, PAT, "R10", 1);
    endtask

    task automatic t_back_to_back();
        run_req(3'd5, 4'd0, 5'd2, 1'b0, ~PAT, "R7", 0);
        run_req(3'd0, 4'd1, 5'd3, 1'b0, ~PAT, "R7", 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_subword();
        t_wide();
        t_fault();
        t_index();
        t_busy();
        t_back_to_back();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule